// File: doc/BRIEF.md
# Parallel Memory Bus Access Sequencer

This block converts 32-bit internal requests into timed accesses on an external parallel memory bus with up to eight chip-selects. Every chip-select has its own 32-bit configuration word, provided on a flat input vector. The word gives the device type, the external data width (8 or 16 bits), whether address and data share the bus, whether reads and writes are synchronous, and five 4-bit cycle counts that set the beat timing.

A request is taken with a valid/ready handshake. It is then split into two 16-bit beats or four 8-bit beats, least significant part first. No byte-select line exists, so each beat steps the word address on `addr_o` by one. The chip-select stays low across every beat of a request. The address-valid, read-strobe and write-strobe pins go low and high at programmed counts within each beat. In multiplexed mode the shared data bus carries the beat address until address-valid rises again. For a read, the sampled lanes are assembled into one 32-bit word. That word is returned with a one-cycle valid pulse after the last beat.

Top module: `ebus_seq`

## Requirements
- R1: After reset the block is idle. `req_ready_o`=1, every `cs_n_o` bit is 1, `adv_n_o`, `oe_n_o` and `we_n_o` are 1, and `dq_oe_o`, `bus_clk_o` and `rsp_valid_o` are 0.
- R2: An accepted request pulls only `cs_n_o[req_cs_i]` low. It stays low for beats×(cycle+1) clock cycles, starting the cycle after acceptance. The count is held in config bits [3:0].
- R3: The size field in config bits [13:12] sets the beat count. Value 00 gives four 8-bit beats; any other value gives two 16-bit beats. During beat k, `addr_o` equals the request address plus k.
- R4: Write data goes out least significant part first. In 16-bit mode beat k drives `wdata[16k+15:16k]`. In 8-bit mode beat k drives `wdata[8k+7:8k]` on `dq_o[7:0]` with `dq_o[15:8]`=0. `dq_oe_o` is high for the whole of every write beat.
- R5: A read returns the beat samples assembled little-endian. In 8-bit mode only `dq_i[7:0]` is used. `rsp_valid_o` is a single-cycle pulse, in the cycle right after the last beat ends.
- R6: Let c be the count within a beat (0 at beat start) and S be config bits [25:22]. For a read, `oe_n_o` is low when c≥S. For a write, `we_n_o` is low when S≤c<cycle. The other strobe stays high.
- R7: `adv_n_o` is low when A≤c<D. A is config bits [17:14] and D is config bits [21:18].
- R8: Multiplexed mode is on when bit 9 is set and type bits [11:10] are 00. In that mode, while c<D, `dq_oe_o`=1 and `dq_o` carries the low 16 bits of the beat address. With any other type, bit 9 has no effect.
- R9: The sample count is P = access time (bits [7:4]) for asynchronous mode and P = access|1 for synchronous mode. If P exceeds the cycle, it is clamped to the cycle. The bus is sampled on the clock edge that ends count P. In synchronous mode `bus_clk_o` is high on odd counts; it is 0 otherwise. Reads use bit 29 as their synchronous flag and writes use bit 27.
- R10: `req_ready_o` is 0 from acceptance to the end of the last beat. A request presented during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | NUM_CS*32 | Configuration word per chip-select, CS n at bits [32n+31:32n] |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W | Target chip-select |
| req_addr_i | input | ADDR_W | Word address of first beat |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 32 | Assembled read data |
| cs_n_o | output | NUM_CS | Chip-selects, active low |
| adv_n_o | output | 1 | Address valid / latch, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| bus_clk_o | output | 1 | Bus clock in synchronous mode |
| addr_o | output | ADDR_W | External address |
| dq_o | output | 16 | Shared bus, driven value |
| dq_oe_o | output | 1 | Shared bus drive enable |
| dq_i | input | 16 | Shared bus, received value |

## Verification
A wrong beat counter or beat index shows up at once at the ports. The chip-select window has the wrong length, or `addr_o` and the write lane step at the wrong cycle. The bench compares every pin on every cycle of every beat, so such a fault is reported in the first cycle it appears. A wrong sample point or wrong read assembly is caught when the response arrives. The modelled device drives valid data only in the single cycle that ends count P and inverted data in all other cycles, so a sample taken one cycle early or late corrupts `rsp_rdata_o`. A mode bit decoded from the wrong field shows up as a stray address phase or bus clock within the first beat.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int TW = 4;   // width of every timing count field

    typedef struct packed {
        logic [1:0]    dtype;
        logic [1:0]    dsize;
        logic          mux;
        logic          rd_sync;
        logic          wr_sync;
        logic [TW-1:0] cyc;
        logic [TW-1:0] acc;
        logic [TW-1:0] adv_on;
        logic [TW-1:0] adv_off;
        logic [TW-1:0] stb_on;
    } cs_cfg_t;

endpackage

// File: rtl/ebus_cfg_sel.sv
module ebus_cfg_sel
    import ebus_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic [NUM_CS*32-1:0] cfg_flat_i,
    input  logic [CS_W-1:0]      sel_i,
    output cs_cfg_t              cfg_o
);

    cs_cfg_t dec [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_dec
        logic [31:0] w;
        logic        unused_bits;
        assign w = cfg_flat_i[g*32 +: 32];
        assign dec[g].cyc     = w[3:0];
        assign dec[g].acc     = w[7:4];
        assign dec[g].mux     = w[9];
        assign dec[g].dtype   = w[11:10];
        assign dec[g].dsize   = w[13:12];
        assign dec[g].adv_on  = w[17:14];
        assign dec[g].adv_off = w[21:18];
        assign dec[g].stb_on  = w[25:22];
        assign dec[g].wr_sync = w[27];
        assign dec[g].rd_sync = w[29];
        assign unused_bits    = ^{w[31:30], w[28], w[26], w[8]};
    end

    assign cfg_o = dec[sel_i];

endmodule

// File: rtl/ebus_lane.sv
module ebus_lane (
    input  logic        byte_mode_i,
    input  logic [1:0]  beat_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] racc_i,
    input  logic [15:0] din_i,
    output logic [15:0] wlane_o,
    output logic [31:0] racc_o
);

    always_comb begin
        racc_o = racc_i;
        if (byte_mode_i) begin
            wlane_o = {8'h00, wdata_i[8*beat_i +: 8]};
            racc_o[8*beat_i +: 8] = din_i[7:0];
        end else begin
            wlane_o = wdata_i[16*beat_i[0] +: 16];
            racc_o[16*beat_i[0] +: 16] = din_i;
        end
    end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 24,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_CS*32-1:0] cfg_i,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic                 req_write_i,
    input  logic [CS_W-1:0]      req_cs_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [31:0]          req_wdata_i,
    output logic                 rsp_valid_o,
    output logic [31:0]          rsp_rdata_o,
    output logic [NUM_CS-1:0]    cs_n_o,
    output logic                 adv_n_o,
    output logic                 oe_n_o,
    output logic                 we_n_o,
    output logic                 bus_clk_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [15:0]          dq_o,
    output logic                 dq_oe_o,
    input  logic [15:0]          dq_i
);

    typedef struct packed {
        logic              busy;
        logic              write;
        logic [CS_W-1:0]   cs;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic [31:0]       rdata;
        logic [TW-1:0]     cnt;
        logic [1:0]        beat;
        logic              rsp;
    } state_t;

    state_t  st_d, st_q;
    cs_cfg_t cfg;

    logic              byte_mode, mux_on, addr_phase, sync_dir;
    logic [1:0]        last_beat;
    logic [TW-1:0]     smp_raw, smp_pt;
    logic [ADDR_W-1:0] beat_addr;
    logic [15:0]       wlane;
    logic [31:0]       racc;

    ebus_cfg_sel #(.NUM_CS(NUM_CS)) u_cfg (
        .cfg_flat_i (cfg_i),
        .sel_i      (st_q.cs),
        .cfg_o      (cfg)
    );

    ebus_lane u_lane (
        .byte_mode_i (byte_mode),
        .beat_i      (st_q.beat),
        .wdata_i     (st_q.wdata),
        .racc_i      (st_q.rdata),
        .din_i       (dq_i),
        .wlane_o     (wlane),
        .racc_o      (racc)
    );

    // per-beat decode of the selected configuration
    always_comb begin
        byte_mode  = (cfg.dsize == 2'b00);
        last_beat  = byte_mode ? 2'd3 : 2'd1;
        mux_on     = cfg.mux && (cfg.dtype == 2'b00);
        addr_phase = mux_on && (st_q.cnt < cfg.adv_off);
        sync_dir   = st_q.write ? cfg.wr_sync : cfg.rd_sync;
        smp_raw    = sync_dir ? (cfg.acc | TW'(1)) : cfg.acc;
        smp_pt     = (smp_raw > cfg.cyc) ? cfg.cyc : smp_raw;
        beat_addr  = st_q.addr + ADDR_W'(st_q.beat);
    end

    // next-state
    always_comb begin
        st_d     = st_q;
        st_d.rsp = 1'b0;
        if (!st_q.busy) begin
            if (req_valid_i) begin
                st_d.busy  = 1'b1;
                st_d.write = req_write_i;
                st_d.cs    = req_cs_i;
                st_d.addr  = req_addr_i;
                st_d.wdata = req_wdata_i;
                st_d.rdata = '0;
                st_d.cnt   = '0;
                st_d.beat  = '0;
            end
        end else begin
            if (!st_q.write && (st_q.cnt == smp_pt)) begin
                st_d.rdata = racc;
            end
            if (st_q.cnt == cfg.cyc) begin
                st_d.cnt = '0;
                if (st_q.beat == last_beat) begin
                    st_d.busy = 1'b0;
                    st_d.rsp  = !st_q.write;
                end else begin
                    st_d.beat = st_q.beat + 2'd1;
                end
            end else begin
                st_d.cnt = st_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // pin drive, decoded from the registered state
    always_comb begin
        cs_n_o = '1;
        if (st_q.busy) begin
            cs_n_o[st_q.cs] = 1'b0;
        end
        req_ready_o = !st_q.busy;
        rsp_valid_o = st_q.rsp;
        rsp_rdata_o = st_q.rdata;
        addr_o      = beat_addr;
        adv_n_o     = !(st_q.busy && (st_q.cnt >= cfg.adv_on) && (st_q.cnt < cfg.adv_off));
        oe_n_o      = !(st_q.busy && !st_q.write && (st_q.cnt >= cfg.stb_on));
        we_n_o      = !(st_q.busy && st_q.write && (st_q.cnt >= cfg.stb_on) && (st_q.cnt < cfg.cyc));
        dq_oe_o     = st_q.busy && (st_q.write || addr_phase);
        dq_o        = addr_phase ? 16'(beat_addr) : wlane;
        bus_clk_o   = st_q.busy && sync_dir && st_q.cnt[0];
    end

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              rsp_valid_o,
    input logic [NUM_CS-1:0] cs_n_o,
    input logic              oe_n_o,
    input logic              we_n_o,
    input logic              dq_oe_o,
    input logic              bus_clk_o
);

    assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~cs_n_o));

    assert_cs_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_ready_o && $past(!req_ready_o)) |-> $stable(cs_n_o));

    assert_we_drives_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_n_o |-> dq_oe_o);

    assert_rsp_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |=> !rsp_valid_o);

    assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!oe_n_o && !we_n_o));

    assert_busclk_in_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_clk_o |-> !(&cs_n_o));

    assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

bind ebus_seq ebus_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .cs_n_o      (cs_n_o),
    .oe_n_o      (oe_n_o),
    .we_n_o      (we_n_o),
    .dq_oe_o     (dq_oe_o),
    .bus_clk_o   (bus_clk_o)
);

// File: tb/ebus_seq_bench.sv
module ebus_seq_bench;

    localparam int NUM_CS = 8;
    localparam int ADDR_W = 24;
    localparam int CS_W   = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_CS*32-1:0] cfg = '0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_write = 1'b0;
    logic [CS_W-1:0]      req_cs = '0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_valid;
    logic [31:0]          rsp_rdata;
    logic [NUM_CS-1:0]    cs_n;
    logic                 adv_n, oe_n, we_n, bus_clk, dq_oe;
    logic [ADDR_W-1:0]    addr;
    logic [15:0]          dq_out;
    logic [15:0]          dq_in = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ebus_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_ebus_seq (
        .clk_i (clk), .rst_ni (rst_n), .cfg_i (cfg),
        .req_valid_i (req_valid), .req_ready_o (req_ready),
        .req_write_i (req_write), .req_cs_i (req_cs),
        .req_addr_i (req_addr), .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid), .rsp_rdata_o (rsp_rdata),
        .cs_n_o (cs_n), .adv_n_o (adv_n), .oe_n_o (oe_n), .we_n_o (we_n),
        .bus_clk_o (bus_clk), .addr_o (addr), .dq_o (dq_out),
        .dq_oe_o (dq_oe), .dq_i (dq_in)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] dev_word(input logic [ADDR_W-1:0] a);
        return {a[7:0] ^ 8'hC3, a[7:0] + 8'h29};
    endfunction

    task automatic run(input int cs, input bit wr, input logic [ADDR_W-1:0] a0,
                       input logic [31:0] wd, input logic [31:0] cw);
        int cyc, acc, aon, aoff, stb, len, beats, smp;
        bit mux, sync, bytem;
        logic [31:0] exp_rd;
        cyc   = int'(cw[3:0]);
        acc   = int'(cw[7:4]);
        aon   = int'(cw[17:14]);
        aoff  = int'(cw[21:18]);
        stb   = int'(cw[25:22]);
        mux   = cw[9] && (cw[11:10] == 2'b00);
        bytem = (cw[13:12] == 2'b00);
        sync  = wr ? cw[27] : cw[29];
        len   = cyc + 1;
        beats = bytem ? 4 : 2;
        smp   = sync ? (acc | 1) : acc;
        if (smp > cyc) smp = cyc;
        exp_rd = '0;
        for (int k = 0; k < beats; k++) begin
            if (bytem) exp_rd[8*k +: 8] = dev_word(a0 + ADDR_W'(k))[7:0];
            else       exp_rd[16*k +: 16] = dev_word(a0 + ADDR_W'(k));
        end

        @(negedge clk);
        cfg[cs*32 +: 32] = cw;
        chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_write = wr;
        req_cs    = CS_W'(cs);
        req_addr  = a0;
        req_wdata = wd;
        @(negedge clk);
        // present a different request during the transfer (R10)
        req_cs    = CS_W'((cs + 1) % NUM_CS);
        req_write = ~wr;
        for (int t = 0; t < beats * len; t++) begin
            int b, c;
            logic [ADDR_W-1:0] ab;
            logic [15:0] edq;
            bit aph;
            b   = t / len;
            c   = t % len;
            ab  = a0 + ADDR_W'(b);
            aph = mux && (c < aoff);
            edq = aph ? ab[15:0] : (bytem ? {8'h00, wd[8*b +: 8]} : wd[16*b +: 16]);
            dq_in = (c == smp) ? dev_word(ab) : ~dev_word(ab);
            chk(cs_n == ~(NUM_CS'(1) << cs), "R2 chip-select", 32'(cs_n), 32'(~(NUM_CS'(1) << cs)));
            chk(addr == ab, "R3 beat address", 32'(addr), 32'(ab));
            chk(adv_n == !(c >= aon && c < aoff), "R7 adv", 32'(adv_n), 32'(!(c >= aon && c < aoff)));
            chk(oe_n == !(!wr && c >= stb), "R6 oe", 32'(oe_n), 32'(!(!wr && c >= stb)));
            chk(we_n == !(wr && c >= stb && c < cyc), "R6 we", 32'(we_n), 32'(!(wr && c >= stb && c < cyc)));
            chk(dq_oe == (wr || aph), "R8 bus drive enable", 32'(dq_oe), 32'(wr || aph));
            if (wr || aph)
                chk(dq_out == edq, aph ? "R8 address phase" : "R4 write lane", 32'(dq_out), 32'(edq));
            chk(bus_clk == (sync && c[0]), "R9 bus clock", 32'(bus_clk), 32'(sync && c[0]));
            chk(req_ready == 1'b0, "R10 busy", 32'(req_ready), 32'd0);
            chk(rsp_valid == 1'b0, "R5 no early response", 32'(rsp_valid), 32'd0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(req_ready == 1'b1, "R10 ready after last beat", 32'(req_ready), 32'd1);
        chk(rsp_valid == !wr, "R5 response pulse", 32'(rsp_valid), 32'(!wr));
        if (!wr) chk(rsp_rdata == exp_rd, "R5 R9 assembled read", rsp_rdata, exp_rd);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R5 single-cycle pulse", 32'(rsp_valid), 32'd0);
        chk(cs_n == '1, "R10 request during transfer not taken", 32'(cs_n), 32'(NUM_CS'('1)));
    endtask

    initial begin
        int idx;
        int tcyc[4] = '{5, 9, 3, 0};
        int tacc[4] = '{4, 6, 7, 0};
        int taon[4] = '{0, 1, 0, 0};
        int taof[4] = '{2, 3, 1, 0};
        int tstb[4] = '{2, 4, 1, 0};
        logic [1:0] sizes[3] = '{2'b00, 2'b01, 2'b10};
        idx = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(cs_n == '1, "R1 cs idle", 32'(cs_n), 32'hFF);
        chk({adv_n, oe_n, we_n} == 3'b111, "R1 strobes idle", 32'({adv_n, oe_n, we_n}), 32'd7);
        chk({dq_oe, bus_clk, rsp_valid} == 3'b000, "R1 drive/clock/resp idle",
            32'({dq_oe, bus_clk, rsp_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == '1, "R1 idle after release", 32'(cs_n), 32'hFF);
        for (int si = 0; si < 3; si++)
            for (int mode = 0; mode < 4; mode++)
                for (int wr = 0; wr < 2; wr++)
                    for (int sy = 0; sy < 2; sy++)
                        for (int ts = 0; ts < 4; ts++) begin
                            logic [31:0] cw;
                            cw = '0;
                            cw[3:0]   = 4'(tcyc[ts]);
                            cw[7:4]   = 4'(tacc[ts]);
                            cw[17:14] = 4'(taon[ts]);
                            cw[21:18] = 4'(taof[ts]);
                            cw[25:22] = 4'(tstb[ts]);
                            cw[9]     = mode[0];
                            cw[11:10] = mode[1] ? 2'b01 : 2'b00;
                            cw[13:12] = sizes[si];
                            cw[29]    = sy[0];
                            cw[27]    = !sy[0];
                            run(idx % NUM_CS, wr[0], 24'h00FFFE + ADDR_W'(idx * 37),
                                32'h1234_5678 ^ (32'(idx) * 32'h0101_0307), cw);
                            idx++;
                        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule